// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Protection

This block keeps a small, fully associative set of virtual-to-physical page translations and decides on each lookup whether the access is allowed. A requester presents a 32-bit virtual address, a read/write flag and a user/kernel flag. The upper 20 bits (the virtual page number) are compared against every stored entry in parallel. On a permitted match, the physical address, made of the stored physical page number and the untouched 12-bit page offset, comes back combinationally in the same cycle. A match that breaks the entry's permissions raises a protection fault instead. No match raises a miss request carrying the page number for an external page walker.

The walker answers with a refill: page number, physical page number, a user-accessible flag and a writable flag. The refill is installed on the next clock edge. If that page number is already held, its entry is overwritten in place. Otherwise the victim slot comes from a FIFO pointer, or from a pseudo-random sequence when a parameter selects it. A single-cycle global invalidate empties the whole array and rewinds the pointer.

Top module: `tlb_xlate`

## Requirements
- R1: On a lookup that matches a valid entry and passes the permission check, `hit` is 1 in the same cycle and `paddr` equals the stored physical page number in bits 31:12, with bits 11:0 copied from `lk_vaddr[11:0]`.
- R2: On a lookup whose page number (`lk_vaddr[31:12]`) matches no valid entry, `miss_req` is 1, `miss_vpn` carries that page number, and `hit` and `prot_fault` are 0. At most one of `hit`, `miss_req` and `prot_fault` is 1 in any cycle.
- R3: A matching lookup with `lk_user`=1 to an entry whose user-accessible flag is 0 gives `prot_fault`=1 and `hit`=0. With `lk_user`=0 the same entry is readable.
- R4: A matching lookup with `lk_write`=1 to an entry whose writable flag is 0 gives `prot_fault`=1 in both privilege modes. A write to an entry with the flag set, and a read to an entry with the flag clear, both hit.
- R5: A refill presented with `fill_valid`=1 at a clock edge can be hit by a lookup from the following cycle onward.
- R6: A refill whose page number is already held overwrites that entry, so later lookups return only the new physical page number, and it does not take a new slot.
- R7: With FIFO replacement (`RANDOM_REPL`=0), refills of new page numbers take slots in cyclic order from slot 0. The refill after ENTRIES new ones evicts the oldest, and the rest stay present.
- R8: `inval_all`=1 at a clock edge makes every entry invalid and rewinds the replacement pointer to slot 0. It takes priority over a refill in the same cycle, and that refill is dropped.
- R9: After synchronous reset (`rst_n`=0 at a clock edge) every entry is invalid and the replacement pointer is at slot 0.
- R10: With `lk_valid`=0, `hit`, `miss_req` and `prot_fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_write | input | 1 | 1 for a write access, 0 for a read |
| lk_user | input | 1 | 1 for user mode, 0 for kernel mode |
| hit | output | 1 | Permitted translation found |
| paddr | output | 32 | Translated physical address, meaningful when hit is 1 |
| prot_fault | output | 1 | Translation found but access denied |
| miss_req | output | 1 | No translation; walk needed |
| miss_vpn | output | 20 | Page number to walk |
| fill_valid | input | 1 | Refill present this cycle |
| fill_vpn | input | 20 | Page number of the refill |
| fill_ppn | input | 20 | Physical page number of the refill |
| fill_user_ok | input | 1 | Refill page may be accessed in user mode |
| fill_write_ok | input | 1 | Refill page may be written |
| inval_all | input | 1 | Invalidate every entry |

## Verification
A corrupted entry shows up on the very next lookup of that page, as a wrong `paddr`, a spurious fault or a miss where a hit was due, because the lookup path holds no state of its own. A faulty replacement pointer stays hidden until the array wraps. It then appears as the wrong page missing after ENTRIES+1 distinct refills, so the bench fills past the wrap and probes the oldest and the next-oldest pages. A duplicate allocation shows at once as an OR of two physical page numbers on `paddr`. The overwrite test uses page numbers whose bits do not overlap, so that this OR is visible.

// File: rtl/tlb_pkg.sv
// Package: shared widths and the stored entry layout for the translation buffer.
// Assumes byte addressing with a fixed page size of 2**TLB_OFF_W bytes.
package tlb_pkg;
    localparam int TLB_VA_W  = 32;
    localparam int TLB_PA_W  = 32;
    localparam int TLB_OFF_W = 12;
    localparam int TLB_VPN_W = TLB_VA_W - TLB_OFF_W;
    localparam int TLB_PPN_W = TLB_PA_W - TLB_OFF_W;

    typedef struct packed {
        logic                 valid;
        logic                 user_ok;
        logic                 write_ok;
        logic [TLB_VPN_W-1:0] vpn;
        logic [TLB_PPN_W-1:0] ppn;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_entry_array.sv
// Module: the entry storage and parallel tag comparators.
// Produces two match vectors (lookup tag and refill tag) and the OR of the
// entries hit by the lookup tag. Assumes at most one entry holds a given tag,
// which the top guarantees by overwriting in place.
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  tlb_entry_t           wr_ent,
    input  logic [TLB_VPN_W-1:0] lk_vpn,
    input  logic [TLB_VPN_W-1:0] fl_vpn,
    output logic [ENTRIES-1:0]   lk_match,
    output logic [ENTRIES-1:0]   fl_match,
    output tlb_entry_t           lk_ent
);
    tlb_entry_t masked [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        tlb_entry_t ent_q;

        // Hold one translation; cleared by reset or global invalidate.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                ent_q <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))
                ent_q <= wr_ent;
        end

        assign lk_match[i] = ent_q.valid && (ent_q.vpn == lk_vpn);
        assign fl_match[i] = ent_q.valid && (ent_q.vpn == fl_vpn);
        assign masked[i]   = lk_match[i] ? ent_q : '0;
    end

    // Merge the matching entries into one read-out word.
    always_comb begin
        lk_ent = '0;
        for (int i = 0; i < ENTRIES; i++)
            lk_ent = lk_ent | masked[i];
    end
endmodule

// File: rtl/tlb_victim_sel.sv
// Module: chooses the slot a new refill replaces.
// RANDOM_REPL=0 gives a wrapping FIFO pointer; otherwise a 16-bit LFSR,
// stepped on each allocation, folded into the index range. Both rewind on clear.
module tlb_victim_sel #(
    parameter int ENTRIES     = 32,
    parameter int RANDOM_REPL = 0,
    localparam int IDX_W      = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] victim
);
    if (RANDOM_REPL == 0) begin : g_fifo
        logic [IDX_W-1:0] ptr_q;

        // Step the FIFO pointer after each new allocation, wrapping at the end.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                ptr_q <= '0;
            else if (advance)
                ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
        assign victim = ptr_q;
    end else begin : g_rand
        logic [15:0]    lfsr_q;
        logic [IDX_W:0] raw;

        // Step the pseudo-random sequence after each new allocation.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                lfsr_q <= 16'hACE1;
            else if (advance)
                lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
        end
        assign raw    = {1'b0, lfsr_q[IDX_W-1:0]};
        assign victim = (raw >= (IDX_W+1)'(ENTRIES)) ? IDX_W'(raw - (IDX_W+1)'(ENTRIES))
                                                     : raw[IDX_W-1:0];
    end
endmodule

// File: rtl/tlb_perm_check.sv
// Module: permission decision for one matched entry.
// User mode needs the user-accessible flag; any write needs the writable flag.
// Kernel reads are always allowed.
module tlb_perm_check (
    input  logic user_ok,
    input  logic write_ok,
    input  logic is_user,
    input  logic is_write,
    output logic deny
);
    assign deny = (is_user && !user_ok) || (is_write && !write_ok);
endmodule

// File: rtl/tlb_xlate.sv
// Module: top of the fully associative translation buffer.
// Combinational lookup with permission check; refills install at the clock
// edge, overwriting a matching tag or else the victim slot. Invalidate wins
// over a same-cycle refill. Assumes ENTRIES >= 2.
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES     = 32,
    parameter int RANDOM_REPL = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic [TLB_VA_W-1:0]  lk_vaddr,
    input  logic                 lk_write,
    input  logic                 lk_user,
    output logic                 hit,
    output logic [TLB_PA_W-1:0]  paddr,
    output logic                 prot_fault,
    output logic                 miss_req,
    output logic [TLB_VPN_W-1:0] miss_vpn,
    input  logic                 fill_valid,
    input  logic [TLB_VPN_W-1:0] fill_vpn,
    input  logic [TLB_PPN_W-1:0] fill_ppn,
    input  logic                 fill_user_ok,
    input  logic                 fill_write_ok,
    input  logic                 inval_all
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [TLB_VPN_W-1:0] lk_vpn;
    logic [ENTRIES-1:0]   lk_match, fl_match;
    tlb_entry_t           lk_ent, wr_ent;
    logic [IDX_W-1:0]     victim, match_idx, wr_idx;
    logic                 fl_present, do_fill, deny, any_match;

    assign lk_vpn = lk_vaddr[TLB_VA_W-1:TLB_OFF_W];

    tlb_entry_array #(.ENTRIES(ENTRIES)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (inval_all),
        .wr_en    (do_fill),
        .wr_idx   (wr_idx),
        .wr_ent   (wr_ent),
        .lk_vpn   (lk_vpn),
        .fl_vpn   (fill_vpn),
        .lk_match (lk_match),
        .fl_match (fl_match),
        .lk_ent   (lk_ent)
    );

    tlb_victim_sel #(.ENTRIES(ENTRIES), .RANDOM_REPL(RANDOM_REPL)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (inval_all),
        .advance (do_fill && !fl_present),
        .victim  (victim)
    );

    tlb_perm_check u_perm (
        .user_ok  (lk_ent.user_ok),
        .write_ok (lk_ent.write_ok),
        .is_user  (lk_user),
        .is_write (lk_write),
        .deny     (deny)
    );

    // Encode the slot already holding the refill tag, if any.
    always_comb begin
        match_idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (fl_match[i]) match_idx = IDX_W'(i);
    end

    assign fl_present = |fl_match;
    assign do_fill    = fill_valid && !inval_all;
    assign wr_idx     = fl_present ? match_idx : victim;

    // Assemble the entry to be written from the refill inputs.
    always_comb begin
        wr_ent          = '0;
        wr_ent.valid    = 1'b1;
        wr_ent.user_ok  = fill_user_ok;
        wr_ent.write_ok = fill_write_ok;
        wr_ent.vpn      = fill_vpn;
        wr_ent.ppn      = fill_ppn;
    end

    assign any_match  = |lk_match;
    assign hit        = lk_valid && any_match && !deny;
    assign prot_fault = lk_valid && any_match && deny;
    assign miss_req   = lk_valid && !any_match;
    assign miss_vpn   = lk_vpn;
    assign paddr      = {lk_ent.ppn, lk_vaddr[TLB_OFF_W-1:0]};
endmodule

// File: rtl/tlb_xlate_chk.sv
// Module: property checker bound to tlb_xlate. Observes ports only.
module tlb_xlate_chk
    import tlb_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lk_valid,
    input logic [TLB_VA_W-1:0]  lk_vaddr,
    input logic                 hit,
    input logic [TLB_PA_W-1:0]  paddr,
    input logic                 prot_fault,
    input logic                 miss_req,
    input logic                 fill_valid,
    input logic [TLB_VPN_W-1:0] fill_vpn,
    input logic                 inval_all
);
    p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit, miss_req, prot_fault}));

    p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(hit || miss_req || prot_fault));

    p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> paddr[TLB_OFF_W-1:0] == lk_vaddr[TLB_OFF_W-1:0]);

    p_fill_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !inval_all) |=>
            !(lk_valid && lk_vaddr[TLB_VA_W-1:TLB_OFF_W] == $past(fill_vpn)) || !miss_req);

    p_inval_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> !(hit || prot_fault));

    p_reset_empty_r9: assert property (@(posedge clk)
        !rst_n |=> !(hit || prot_fault));
endmodule

bind tlb_xlate tlb_xlate_chk chk_i (.*);

// File: tb/tlb_xlate_tb_top.sv
// Scoreboard bench for tlb_xlate: driver tasks queue expected outcomes,
// a monitor pops and compares them at the following rising edge.
module tlb_xlate_tb_top;
    localparam int N = 32;
    localparam logic [1:0] K_IDLE = 2'd0, K_HIT = 2'd1, K_MISS = 2'd2, K_FAULT = 2'd3;

    typedef struct {
        logic [1:0]  kind;
        logic [31:0] pa;
        logic [19:0] vpn;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0, lk_user = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        hit, prot_fault, miss_req;
    logic [31:0] paddr;
    logic [19:0] miss_vpn;
    logic        fill_valid = 1'b0, fill_user_ok = 1'b0, fill_write_ok = 1'b0, inval_all = 1'b0;
    logic [19:0] fill_vpn = '0, fill_ppn = '0;

    int   checks = 0, failures = 0;
    exp_t sb_q[$];
    bit   done = 1'b0;

    always #5 clk = ~clk;

    tlb_xlate #(.ENTRIES(N)) dut_i (.*);

    // Monitor: compare one queued expectation per rising edge.
    always @(posedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            logic [1:0] got;
            e   = sb_q.pop_front();
            got = hit ? K_HIT : miss_req ? K_MISS : prot_fault ? K_FAULT : K_IDLE;
            checks++;
            if ({hit, miss_req, prot_fault} != {e.kind == K_HIT, e.kind == K_MISS, e.kind == K_FAULT}) begin
                failures++;
                $display("FAIL %s outcome h/m/f=%b%b%b got=%0d expected=%0d",
                         e.tag, hit, miss_req, prot_fault, got, e.kind);
            end else if (e.kind == K_HIT && paddr !== e.pa) begin
                failures++;
                $display("FAIL %s paddr=%h expected=%h", e.tag, paddr, e.pa);
            end else if (e.kind == K_MISS && miss_vpn !== e.vpn) begin
                failures++;
                $display("FAIL %s miss_vpn=%h expected=%h", e.tag, miss_vpn, e.vpn);
            end
        end
    end

    task automatic look(input logic v, input logic [31:0] va, input logic wr, input logic usr,
                        input logic [1:0] kind, input logic [19:0] ppn, input string tag);
        exp_t e;
        @(negedge clk);
        lk_valid = v; lk_vaddr = va; lk_write = wr; lk_user = usr;
        e.kind = kind; e.pa = {ppn, va[11:0]}; e.vpn = va[31:12]; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic u, input logic w, input logic inv);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
        fill_user_ok = u; fill_write_ok = w; inval_all = inv;
        @(negedge clk);
        fill_valid = 1'b0; inval_all = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired got=running expected=done");
            finish_run();
        end
    end

    // Stimulus sequence.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9 / R2: empty after reset, miss carries page number
        look(1, 32'h12345678, 0, 1, K_MISS, '0, "R9 R2 reset empty miss");
        // R10: no lookup, no outcome
        look(0, 32'h12345678, 0, 1, K_IDLE, '0, "R10 idle quiet");

        // R5 / R1: refill visible next cycle, offset passes through
        fill(20'h12345, 20'h00ABC, 1, 1, 0);
        look(1, 32'h12345678, 0, 1, K_HIT, 20'h00ABC, "R1 R5 user read hit");
        look(1, 32'h12345FFF, 1, 1, K_HIT, 20'h00ABC, "R1 user write hit");

        // R3: kernel-only page
        fill(20'h00010, 20'h00777, 0, 1, 0);
        look(1, 32'h00010123, 0, 1, K_FAULT, '0, "R3 user read of kernel page");
        look(1, 32'h00010123, 0, 0, K_HIT, 20'h00777, "R3 kernel read");
        look(1, 32'h00010124, 1, 0, K_HIT, 20'h00777, "R4 kernel write writable");

        // R4: read-only page
        fill(20'h00020, 20'h00888, 1, 0, 0);
        look(1, 32'h00020010, 1, 1, K_FAULT, '0, "R4 user write read-only");
        look(1, 32'h00020010, 1, 0, K_FAULT, '0, "R4 kernel write read-only");
        look(1, 32'h00020010, 0, 1, K_HIT, 20'h00888, "R4 user read read-only");

        // R6: overwrite in place, non-overlapping page numbers expose duplicates
        fill(20'h00030, 20'h0F0F0, 1, 1, 0);
        fill(20'h00030, 20'h00F0F, 1, 1, 0);
        look(1, 32'h00030ABC, 0, 0, K_HIT, 20'h00F0F, "R6 overwrite returns new ppn");

        // R8: invalidate clears all and wins over a same-cycle refill
        fill(20'h00040, 20'h00444, 1, 1, 1);
        look(1, 32'h12345678, 0, 0, K_MISS, '0, "R8 cleared entry misses");
        look(1, 32'h00030000, 0, 0, K_MISS, '0, "R8 cleared entry misses");
        look(1, 32'h00040000, 0, 0, K_MISS, '0, "R8 dropped refill misses");

        // R7: FIFO order across a wrap
        for (int i = 0; i < N; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 1, 1, 0);
        look(1, 32'h00100004, 0, 0, K_HIT, 20'h00200, "R7 first of full set");
        look(1, {20'h00100 + 20'(N - 1), 12'h008}, 0, 0, K_HIT, 20'h00200 + 20'(N - 1), "R7 last of full set");
        fill(20'h00300, 20'h00333, 1, 1, 0);
        look(1, 32'h00100004, 0, 0, K_MISS, '0, "R7 oldest evicted");
        look(1, 32'h00101004, 0, 0, K_HIT, 20'h00201, "R7 second oldest kept");
        look(1, 32'h00300004, 0, 0, K_HIT, 20'h00333, "R7 newest present");
        fill(20'h00301, 20'h00334, 1, 1, 0);
        look(1, 32'h00101004, 0, 0, K_MISS, '0, "R7 next oldest evicted");
        look(1, 32'h00102004, 0, 0, K_HIT, 20'h00202, "R7 third oldest kept");

        repeat (2) @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule